// File: doc/BRIEF.md
# Self-Triggered Gated Integrator Sequencer

This block sequences the digital side of a gated-integrator pulse channel. A discriminator in the front end goes high when a pulse arrives. On a rising edge of that signal, and only while the channel is idle, the sequencer enables the integrator for a programmable gate. It then holds the integrated value while a conversion strobe tells the downstream converter to sample. Next it discharges the integrator for a programmable time, and finally it rearms. The lengths of all three timed phases come from configuration registers, so every phase of the channel is timed by this block.

The gate is counted in clock ticks. The gate register accepts any value, but the stored value is clamped to a parameterised window. With a 10 ns tick, the default window of 20 to 1100 ticks spans 200 ns to 11 us. The sample and discharge durations each come from their own 8-bit register. A 6-bit code that tunes the front-end input bias is also held here and driven straight out. Discriminator edges that come in while the channel is busy do not start anything, but they are tallied in a saturating pile-up counter.

Top module: `gint_ctrl`

## Requirements
- R1: After reset the phase output is 0 (idle), `integ_en`, `conv_strobe`, `int_rst` and `busy` are low, the pile-up count is 0, and the defaults take effect: gate 100 ticks, sample 4, discharge 4, bias code 32.
- R2: A rising edge on `disc` seen at a clock edge while idle moves the sequencer to integrate at that same edge. `integ_en` is then high for exactly the programmed gate length in cycles.
- R3: Writing address 0 sets the gate length from the 16-bit write data. Values below 20 are stored as 20 and values above 1100 are stored as 1100.
- R4: When the gate ends, `conv_strobe` is high for the number of cycles set at address 1 (bits 7:0). A value of 0 gives one cycle.
- R5: When the sample phase ends, `int_rst` is high for the number of cycles set at address 2 (bits 7:0). A value of 0 gives one cycle.
- R6: The phases always run in the order idle(0), integrate(1), sample(2), discharge(3) and back to idle(0). The code is driven on `phase`.
- R7: `busy` is high exactly when the phase is not idle, and at most one of `integ_en`, `conv_strobe`, `int_rst` is high at any time.
- R8: A rising edge on `disc` outside idle does not change the running sequence. It adds one to `pileup_cnt`, which stops at its all-ones value.
- R9: Only a rising edge starts a sequence. A `disc` level that stays high after the sequencer returns to idle starts nothing.
- R10: Writing address 3 sets `bias_code` from write data bits 5:0.
- R11: A gate write made during integration does not change the length of that integration. It applies from the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one gate tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disc | input | 1 | Discriminator output, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 gate, 1 sample, 2 discharge, 3 bias |
| cfg_wdata | input | 16 | Configuration write data |
| integ_en | output | 1 | Integrator enable (gate) |
| conv_strobe | output | 1 | Conversion strobe during the sample phase |
| int_rst | output | 1 | Integrator discharge |
| busy | output | 1 | High in every phase except idle |
| phase | output | 2 | Current phase code |
| bias_code | output | 6 | Front-end input bias setting |
| pileup_cnt | output | 8 | Saturating count of edges ignored while busy |

## Verification
If the phase timer is loaded with the wrong value, or decremented wrongly, the error shows up as a gate, strobe or discharge pulse that is one or more cycles too long or too short. This is visible at the ports within the first pulse after the fault. A sequencer that skips or reorders a phase makes one of the three outputs absent, or makes two of them overlap, during that same pulse. A wrong clamp or a missed edge qualification shows up either as a mismatch in the measured gate length, or as `busy` rising when no new edge has arrived. The pile-up tally is read directly, after bursts of known size and after a burst long enough to saturate it.

// File: rtl/gint_pkg.sv
package gint_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_HOLD  = 2'd2,
    PH_DUMP  = 2'd3
  } phase_e;

  localparam logic [1:0] ADR_GATE = 2'd0;
  localparam logic [1:0] ADR_HOLD = 2'd1;
  localparam logic [1:0] ADR_DUMP = 2'd2;
  localparam logic [1:0] ADR_BIAS = 2'd3;
endpackage

// File: rtl/gint_cfg.sv
module gint_cfg
  import gint_pkg::*;
#(
  parameter int WD_W     = 16,
  parameter int GATE_MIN = 20,
  parameter int GATE_MAX = 1100,
  parameter int GATE_DEF = 100,
  parameter int GATE_W   = 11,
  parameter int DUR_W    = 8,
  parameter int HOLD_DEF = 4,
  parameter int DUMP_DEF = 4,
  parameter int BIAS_W   = 6,
  parameter int BIAS_DEF = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [WD_W-1:0]   wdata,
  output logic [GATE_W-1:0] gate_len,
  output logic [DUR_W-1:0]  hold_len,
  output logic [DUR_W-1:0]  dump_len,
  output logic [BIAS_W-1:0] bias
);
  localparam logic [WD_W-1:0] LO = WD_W'(GATE_MIN);
  localparam logic [WD_W-1:0] HI = WD_W'(GATE_MAX);

  logic [GATE_W-1:0] gate_clamped;
  logic [DUR_W-1:0]  dur_fixed;
  logic              gate_en, hold_en, dump_en, bias_en;

  always_comb begin
    if (wdata < LO)      gate_clamped = GATE_W'(GATE_MIN);
    else if (wdata > HI) gate_clamped = GATE_W'(GATE_MAX);
    else                 gate_clamped = wdata[GATE_W-1:0];
    dur_fixed = (wdata[DUR_W-1:0] == '0) ? DUR_W'(1) : wdata[DUR_W-1:0];
    gate_en = we && (addr == ADR_GATE);
    hold_en = we && (addr == ADR_HOLD);
    dump_en = we && (addr == ADR_DUMP);
    bias_en = we && (addr == ADR_BIAS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_len <= GATE_W'(GATE_DEF);
      hold_len <= DUR_W'(HOLD_DEF);
      dump_len <= DUR_W'(DUMP_DEF);
      bias     <= BIAS_W'(BIAS_DEF);
    end else begin
      if (gate_en) gate_len <= gate_clamped;
      if (hold_en) hold_len <= dur_fixed;
      if (dump_en) dump_len <= dur_fixed;
      if (bias_en) bias     <= wdata[BIAS_W-1:0];
    end
  end

  assert_gate_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_len >= GATE_W'(GATE_MIN)) && (gate_len <= GATE_W'(GATE_MAX)));
  assert_dur_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_len != '0) && (dump_len != '0));
endmodule

// File: rtl/gint_edge.sv
module gint_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level && !level_q;
endmodule

// File: rtl/gint_seq.sv
module gint_seq
  import gint_pkg::*;
#(
  parameter int GATE_W = 11,
  parameter int DUR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [GATE_W-1:0] gate_len,
  input  logic [DUR_W-1:0]  hold_len,
  input  logic [DUR_W-1:0]  dump_len,
  output phase_e            phase,
  output logic              integ_en,
  output logic              conv_strobe,
  output logic              int_rst,
  output logic              busy,
  output logic              ignored
);
  localparam int CNT_W = (GATE_W > DUR_W) ? GATE_W : DUR_W;

  phase_e           state_q, state_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    unique case (state_q)
      PH_IDLE: if (start) begin
        state_nx = PH_INTEG;
        cnt_nx   = CNT_W'(gate_len - 1'b1);
      end
      PH_INTEG: if (last) begin
        state_nx = PH_HOLD;
        cnt_nx   = CNT_W'(hold_len - 1'b1);
      end else cnt_nx = cnt_q - 1'b1;
      PH_HOLD: if (last) begin
        state_nx = PH_DUMP;
        cnt_nx   = CNT_W'(dump_len - 1'b1);
      end else cnt_nx = cnt_q - 1'b1;
      PH_DUMP: if (last) state_nx = PH_IDLE;
        else cnt_nx = cnt_q - 1'b1;
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PH_IDLE;
      cnt_q       <= '0;
      integ_en    <= 1'b0;
      conv_strobe <= 1'b0;
      int_rst     <= 1'b0;
      busy        <= 1'b0;
    end else begin
      state_q     <= state_nx;
      cnt_q       <= cnt_nx;
      integ_en    <= (state_nx == PH_INTEG);
      conv_strobe <= (state_nx == PH_HOLD);
      int_rst     <= (state_nx == PH_DUMP);
      busy        <= (state_nx != PH_IDLE);
    end
  end

  assign phase   = state_q;
  assign ignored = start && (state_q != PH_IDLE);

  assert_gate_then_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_en) |-> conv_strobe);
  assert_hold_then_dump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_strobe) |-> int_rst);
  assert_dump_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> (!busy && phase == PH_IDLE));
  assert_busy_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({integ_en, conv_strobe, int_rst}) &&
    (busy == (integ_en || conv_strobe || int_rst)));
  assert_ignored_keeps_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored && !last) |=> (phase == $past(phase)));
endmodule

// File: rtl/gint_pileup.sv
module gint_pileup #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  logic             inc_en;
  logic [CNT_W-1:0] count_nx;

  always_comb begin
    inc_en   = hit && (count != '1);
    count_nx = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (inc_en) count <= count_nx;
  end

  assert_pileup_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && count != '1) |=> (count == $past(count) + 1'b1));
  assert_pileup_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || count == '1) |=> $stable(count));
endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl
  import gint_pkg::*;
#(
  parameter int WD_W     = 16,
  parameter int GATE_MIN = 20,
  parameter int GATE_MAX = 1100,
  parameter int GATE_DEF = 100,
  parameter int DUR_W    = 8,
  parameter int HOLD_DEF = 4,
  parameter int DUMP_DEF = 4,
  parameter int BIAS_W   = 6,
  parameter int BIAS_DEF = 32,
  parameter int PILE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [WD_W-1:0]   cfg_wdata,
  output logic              integ_en,
  output logic              conv_strobe,
  output logic              int_rst,
  output logic              busy,
  output logic [1:0]        phase,
  output logic [BIAS_W-1:0] bias_code,
  output logic [PILE_W-1:0] pileup_cnt
);
  localparam int GATE_W = $clog2(GATE_MAX + 1);

  logic              disc_rise, ignored;
  logic [GATE_W-1:0] gate_len;
  logic [DUR_W-1:0]  hold_len, dump_len;
  phase_e            phase_s;

  gint_cfg #(
    .WD_W(WD_W), .GATE_MIN(GATE_MIN), .GATE_MAX(GATE_MAX), .GATE_DEF(GATE_DEF),
    .GATE_W(GATE_W), .DUR_W(DUR_W), .HOLD_DEF(HOLD_DEF), .DUMP_DEF(DUMP_DEF),
    .BIAS_W(BIAS_W), .BIAS_DEF(BIAS_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .gate_len(gate_len), .hold_len(hold_len), .dump_len(dump_len), .bias(bias_code)
  );

  gint_edge u_edge (.clk(clk), .rst_n(rst_n), .level(disc), .rise(disc_rise));

  gint_seq #(.GATE_W(GATE_W), .DUR_W(DUR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(disc_rise),
    .gate_len(gate_len), .hold_len(hold_len), .dump_len(dump_len),
    .phase(phase_s), .integ_en(integ_en), .conv_strobe(conv_strobe),
    .int_rst(int_rst), .busy(busy), .ignored(ignored)
  );

  gint_pileup #(.CNT_W(PILE_W)) u_pile (
    .clk(clk), .rst_n(rst_n), .hit(ignored), .count(pileup_cnt)
  );

  assign phase = phase_s;

  assert_start_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integ_en) |-> $past(disc_rise));
  assert_level_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_s == PH_IDLE && !disc_rise) |=> !busy);
endmodule

// File: tb/gint_ctrl_tb.sv
module gint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disc = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        integ_en, conv_strobe, int_rst, busy;
  logic [1:0]  phase;
  logic [5:0]  bias_code;
  logic [7:0]  pileup_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gint_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .disc(disc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .integ_en(integ_en), .conv_strobe(conv_strobe),
    .int_rst(int_rst), .busy(busy), .phase(phase), .bias_code(bias_code),
    .pileup_cnt(pileup_cnt)
  );

  typedef struct packed {
    logic [15:0] gate_in;
    logic [15:0] hold_in;
    logic [15:0] dump_in;
    logic [15:0] gate_x;
    logic [15:0] hold_x;
    logic [15:0] dump_x;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd100,  16'd4,   16'd4, 16'd100,  16'd4,   16'd4},
    '{16'd20,   16'd1,   16'd1, 16'd20,   16'd1,   16'd1},
    '{16'd5,    16'd0,   16'd0, 16'd20,   16'd1,   16'd1},
    '{16'd1100, 16'd255, 16'd2, 16'd1100, 16'd255, 16'd2},
    '{16'd3000, 16'd7,   16'd9, 16'd1100, 16'd7,   16'd9},
    '{16'd19,   16'd2,   16'd0, 16'd20,   16'd2,   16'd1},
    '{16'd21,   16'd3,   16'd3, 16'd21,   16'd3,   16'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Fires one pulse and measures each phase width; optional write at gate cycle 5.
  task automatic pulse(input bit mid_wr, input logic [15:0] mid_data,
                       output int ig, output int hd, output int dp, output int order_err);
    int last_ph;
    int guard;
    ig = 0; hd = 0; dp = 0; order_err = 0; last_ph = 1; guard = 0;
    @(negedge clk);
    disc = 1'b1;
    @(negedge clk);
    disc = 1'b0;
    while (busy && guard < 5000) begin
      cfg_we = 1'b0;
      if (phase < last_ph) order_err++;
      if ((integ_en + conv_strobe + int_rst) != 1) order_err++;
      last_ph = phase;
      if (integ_en) ig++;
      if (conv_strobe) hd++;
      if (int_rst) dp++;
      if (mid_wr && ig == 5 && integ_en) begin
        cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = mid_data;
      end
      guard++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    if (phase != 0) order_err++;
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ig, hd, dp, oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 phase", phase, 0);
    check("R1 busy", busy, 0);
    check("R1 outputs", {integ_en, conv_strobe, int_rst}, 0);
    check("R1 pileup", pileup_cnt, 0);
    check("R1 bias", bias_code, 32);
    pulse(1'b0, 16'd0, ig, hd, dp, oe);
    check("R1 default gate", ig, 100);
    check("R1 default hold", hd, 4);
    check("R1 default dump", dp, 4);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, VECS[i].gate_in);
      cfg_write(2'd1, VECS[i].hold_in);
      cfg_write(2'd2, VECS[i].dump_in);
      pulse(1'b0, 16'd0, ig, hd, dp, oe);
      check("R2/R3 gate width", ig, int'(VECS[i].gate_x));
      check("R4 hold width", hd, int'(VECS[i].hold_x));
      check("R5 dump width", dp, int'(VECS[i].dump_x));
      check("R6/R7 phase order", oe, 0);
    end

    // R2 start latency: edge at a clock edge gives integrate right after
    cfg_write(2'd0, 16'd30);
    @(negedge clk);
    disc = 1'b1;
    @(negedge clk);
    check("R2 start next edge", {busy, integ_en, phase}, {1'b1, 1'b1, 2'd1});
    disc = 1'b0;
    while (busy) @(negedge clk);

    // R10 bias
    cfg_write(2'd3, 16'hFFC5);
    check("R10 bias", bias_code, 6'h05);

    // R11 gate write mid-integration
    cfg_write(2'd1, 16'd2);
    cfg_write(2'd2, 16'd2);
    pulse(1'b1, 16'd200, ig, hd, dp, oe);
    check("R11 current gate kept", ig, 30);
    pulse(1'b0, 16'd0, ig, hd, dp, oe);
    check("R11 next gate new", ig, 200);

    // R8 pile-up during integration
    cfg_write(2'd0, 16'd50);
    @(negedge clk); disc = 1'b1;
    @(negedge clk); disc = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); disc = 1'b1;
      @(negedge clk); disc = 1'b0;
    end
    check("R8 sequence unchanged", integ_en, 1);
    while (busy) @(negedge clk);
    check("R8 pileup count", pileup_cnt, 3);

    // R8 edge during discharge ignored
    cfg_write(2'd0, 16'd20);
    cfg_write(2'd1, 16'd1);
    cfg_write(2'd2, 16'd40);
    @(negedge clk); disc = 1'b1;
    @(negedge clk); disc = 1'b0;
    while (!int_rst) @(negedge clk);
    disc = 1'b1;
    @(negedge clk); disc = 1'b0;
    check("R8 dump continues", int_rst, 1);
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 no restart", busy, 0);
    check("R8 pileup dump edge", pileup_cnt, 4);

    // R9 level held across return to idle
    cfg_write(2'd2, 16'd3);
    @(negedge clk); disc = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R9 level no retrigger", busy, 0);
    disc = 1'b0;
    @(negedge clk);

    // R8 saturation
    cfg_write(2'd0, 16'd1100);
    @(negedge clk); disc = 1'b1;
    @(negedge clk); disc = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); disc = 1'b1;
      @(negedge clk); disc = 1'b0;
    end
    while (busy) @(negedge clk);
    check("R8 saturate", pileup_cnt, 255);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule